// File: doc/BRIEF.md
# Processor Slot Hotplug Register Block

This block gives guest software a small window of twelve bytes through which it manages a set of processor slots. Software first writes a slot number into a selector. After that, every other register refers to the selected slot: software can read the slot's status, clear its pending insert or remove events, and read that slot's architectural processor ID in two 32-bit halves. A search command moves the selector to the lowest-numbered slot that has an event pending, so software finds work with a few accesses. Two capture registers take the progress codes and the final status that software reports while it handles an event. A write to the status register produces a one-cycle pulse.

The platform side raises hot-add and hot-remove requests as single-cycle pulses, each with a slot number. The bus uses 32-bit words with byte enables. Word 0 covers bytes 0x0 to 0x3, word 1 covers bytes 0x4 to 0x7 and word 2 covers bytes 0x8 to 0xB. All values are little-endian, so byte k of a word is data bits [8k+7:8k]. Word 3 lies outside the block. Read data is combinational while `bus_rd` is high. A write takes effect at the clock edge on which `bus_wr` is sampled high.

The selector is persistent. Its value is checked against the slot count. While the selector points past the last slot, every other register is silent until a valid selector is stored.

Top module: `cpuhp_regs`

## Requirements
- R1: Writing word 0 stores the byte-enabled bytes into the 32-bit selector. While the stored command is 0, reading word 2 returns the selector. The selector starts at 0, and asserting `rst_n` low leaves it unchanged.
- R2: While the selector is MAX_SLOTS or greater, every read returns 0. In that state, writes to words 1 and 2 are discarded: command, flags and capture registers keep their values. A write to word 0 is still accepted.
- R3: Reading word 1 returns the selected slot's status in byte 0: bit 0 enabled, bit 1 insert pending, bit 2 remove pending. Bits 31 to 3 read as 0.
- R4: A hot-add pulse sets the enabled and insert-pending flags of its slot. A hot-remove pulse sets the remove-pending flag of its slot.
- R5: A write of byte 0 of word 1 acts on the selected slot. Bit 1 clears insert pending. Bit 2 clears remove pending and enabled. Bit 0 has no effect.
- R6: A write of byte 1 of word 1 stores the command. Command value 0 moves the selector, at the same edge, to the lowest-numbered slot with insert or remove pending. It uses the flags as they stood before that edge. If no slot has an event pending, the selector and all flags are unchanged.
- R7: The architectural ID of slot s is ID_BASE + s*ID_STRIDE (64 bits). Reading word 2 returns the selector for command 0 and ID bits 31..0 for command 3. For any other command it returns 0.
- R8: Reading word 0 returns ID bits 63..32 when the command is 3, and 0 for any other command.
- R9: A byte-enabled write to word 2 goes into the event capture register when the command is 1. When the command is 2 it goes into the status capture register, and `ost_pulse_o` is high for exactly the cycle after that write edge. The pulse is low at all other times.
- R10: Bytes 2 and 3 of word 1, and all of word 3, read as 0 and ignore writes. Read bytes whose enable is low return 0.
- R11: Reset clears all slot flags, sets the command to 0 and clears both capture registers and the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 2 | Word index (0 to 2 used, 3 outside the block) |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| add_req | input | 1 | Hot-add request pulse |
| add_slot | input | SEL_W | Slot of hot-add request |
| rem_req | input | 1 | Hot-remove request pulse |
| rem_slot | input | SEL_W | Slot of hot-remove request |
| ost_event_o | output | 32 | Event capture register |
| ost_status_o | output | 32 | Status capture register |
| ost_pulse_o | output | 1 | One-cycle pulse after a status capture write |

## Verification
The bench builds the block with MAX_SLOTS = 6. Selector values 6 and 7 still fit the three-bit slot index, so the range check cannot be replaced by a wrap of the index width. ID_BASE is set with a nonzero upper half and ID_STRIDE is set to 3, which makes both halves of the ID visible and distinct for each slot. With six slots, the random phase often has several events pending together, and this exercises the lowest-index-first order of the search.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned BYTES_W = BUS_W / 8;

   localparam logic [1:0] W_IDHI = 2'd0;
   localparam logic [1:0] W_STAT = 2'd1;
   localparam logic [1:0] W_DATA = 2'd2;

   localparam logic [7:0] CMD_SCAN   = 8'd0;
   localparam logic [7:0] CMD_OSTEV  = 8'd1;
   localparam logic [7:0] CMD_OSTST  = 8'd2;
   localparam logic [7:0] CMD_ARCHID = 8'd3;

   function automatic logic [BUS_W-1:0] be_merge(input logic [BUS_W-1:0] old_v,
                                                 input logic [BUS_W-1:0] new_v,
                                                 input logic [BYTES_W-1:0] be);
      logic [BUS_W-1:0] r;
      r = old_v;
      for (int b = 0; b < int'(BYTES_W); b++)
         if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
      return r;
   endfunction

   function automatic logic [BUS_W-1:0] be_mask(input logic [BYTES_W-1:0] be);
      logic [BUS_W-1:0] m;
      for (int b = 0; b < int'(BYTES_W); b++)
         m[8*b +: 8] = {8{be[b]}};
      return m;
   endfunction
endpackage

// File: rtl/cpuhp_slot_array.sv
module cpuhp_slot_array #(
   parameter int unsigned N  = 8,
   parameter int unsigned SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          add_req,
   input  logic [SW-1:0] add_slot,
   input  logic          rem_req,
   input  logic [SW-1:0] rem_slot,
   input  logic          ack_en,
   input  logic [SW-1:0] ack_slot,
   input  logic          ack_ins,
   input  logic          ack_rem,
   output logic [N-1:0]  en_o,
   output logic [N-1:0]  ins_o,
   output logic [N-1:0]  rem_o
);
   for (genvar i = 0; i < int'(N); i++) begin : g_slot
      logic hit_add, hit_rem, hit_ack;
      assign hit_add = add_req && (add_slot == SW'(i));
      assign hit_rem = rem_req && (rem_slot == SW'(i));
      assign hit_ack = ack_en  && (ack_slot == SW'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_o[i]  <= 1'b0;
            ins_o[i] <= 1'b0;
            rem_o[i] <= 1'b0;
         end else begin
            if (hit_ack && ack_ins) ins_o[i] <= 1'b0;
            if (hit_ack && ack_rem) begin
               rem_o[i] <= 1'b0;
               en_o[i]  <= 1'b0;
            end
            if (hit_add) begin
               en_o[i]  <= 1'b1;
               ins_o[i] <= 1'b1;
            end
            if (hit_rem) rem_o[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cpuhp_pend_scan.sv
module cpuhp_pend_scan #(
   parameter int unsigned N  = 8,
   parameter int unsigned SW = 3
) (
   input  logic [N-1:0]  pend,
   output logic          found,
   output logic [SW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (pend[i]) begin
            found = 1'b1;
            idx   = SW'(i);
         end
      end
   end
endmodule

// File: rtl/cpuhp_regs.sv
module cpuhp_regs
   import cpuhp_pkg::*;
#(
   parameter int unsigned MAX_SLOTS = 8,
   parameter logic [63:0] ID_BASE   = 64'h0000_00A5_0000_0010,
   parameter logic [63:0] ID_STRIDE = 64'd2,
   localparam int unsigned SEL_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_word,
   input  logic [3:0]       bus_be,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic             add_req,
   input  logic [SEL_W-1:0] add_slot,
   input  logic             rem_req,
   input  logic [SEL_W-1:0] rem_slot,
   output logic [31:0]      ost_event_o,
   output logic [31:0]      ost_status_o,
   output logic             ost_pulse_o
);
   if (MAX_SLOTS < 1 || MAX_SLOTS > 1024) begin : g_bad_slots
      $error("cpuhp_regs: MAX_SLOTS must lie in 1..1024");
   end
   if (ID_STRIDE == 64'd0) begin : g_bad_stride
      $error("cpuhp_regs: ID_STRIDE must be nonzero");
   end

   logic [31:0]      sel_q = '0;
   logic             sel_valid;
   logic [SEL_W-1:0] sel_idx;
   logic [7:0]       cmd_q;
   logic [MAX_SLOTS-1:0] slot_en, slot_ins, slot_rem;
   logic             scan_found;
   logic [SEL_W-1:0] scan_idx;
   logic             scan_go;
   logic             wr_sel, wr_ctl, wr_cmd, wr_data;
   logic [63:0]      arch_id;
   logic [31:0]      rd_raw;

   assign sel_valid = (sel_q < 32'(MAX_SLOTS));
   assign sel_idx   = sel_q[SEL_W-1:0];

   assign wr_sel  = bus_wr && (bus_word == W_IDHI);
   assign wr_ctl  = bus_wr && (bus_word == W_STAT) && bus_be[0] && sel_valid;
   assign wr_cmd  = bus_wr && (bus_word == W_STAT) && bus_be[1] && sel_valid;
   assign wr_data = bus_wr && (bus_word == W_DATA) && sel_valid;
   assign scan_go = wr_cmd && (bus_wdata[15:8] == CMD_SCAN);

   cpuhp_slot_array #(.N(MAX_SLOTS), .SW(SEL_W)) slots_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_req  (add_req),
      .add_slot (add_slot),
      .rem_req  (rem_req),
      .rem_slot (rem_slot),
      .ack_en   (wr_ctl),
      .ack_slot (sel_idx),
      .ack_ins  (bus_wdata[1]),
      .ack_rem  (bus_wdata[2]),
      .en_o     (slot_en),
      .ins_o    (slot_ins),
      .rem_o    (slot_rem)
   );

   cpuhp_pend_scan #(.N(MAX_SLOTS), .SW(SEL_W)) scan_i (
      .pend  (slot_ins | slot_rem),
      .found (scan_found),
      .idx   (scan_idx)
   );

   // Selector: no reset, so a platform reset keeps the guest's choice.
   always_ff @(posedge clk) begin
      if (wr_sel)
         sel_q <= be_merge(sel_q, bus_wdata, bus_be);
      else if (scan_go && scan_found)
         sel_q <= 32'(scan_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q        <= CMD_SCAN;
         ost_event_o  <= '0;
         ost_status_o <= '0;
         ost_pulse_o  <= 1'b0;
      end else begin
         ost_pulse_o <= 1'b0;
         if (wr_cmd) cmd_q <= bus_wdata[15:8];
         if (wr_data && cmd_q == CMD_OSTEV)
            ost_event_o <= be_merge(ost_event_o, bus_wdata, bus_be);
         if (wr_data && cmd_q == CMD_OSTST) begin
            ost_status_o <= be_merge(ost_status_o, bus_wdata, bus_be);
            ost_pulse_o  <= 1'b1;
         end
      end
   end

   assign arch_id = ID_BASE + (64'(sel_idx) * ID_STRIDE);

   always_comb begin
      rd_raw = '0;
      if (sel_valid) begin
         case (bus_word)
            W_IDHI: if (cmd_q == CMD_ARCHID) rd_raw = arch_id[63:32];
            W_STAT: rd_raw = {29'd0, slot_rem[sel_idx], slot_ins[sel_idx], slot_en[sel_idx]};
            W_DATA: begin
               if (cmd_q == CMD_SCAN)        rd_raw = sel_q;
               else if (cmd_q == CMD_ARCHID) rd_raw = arch_id[31:0];
            end
            default: rd_raw = '0;
         endcase
      end
   end

   assign bus_rdata = bus_rd ? (rd_raw & be_mask(bus_be)) : '0;
endmodule

// File: rtl/cpuhp_regs_chk.sv
module cpuhp_regs_chk #(
   parameter int unsigned MAX_SLOTS = 8,
   parameter int unsigned SEL_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [1:0]           bus_word,
   input logic [31:0]          bus_rdata,
   input logic                 add_req,
   input logic [SEL_W-1:0]     add_slot,
   input logic [31:0]          sel_q,
   input logic                 sel_valid,
   input logic [7:0]           cmd_q,
   input logic                 scan_go,
   input logic                 scan_found,
   input logic [MAX_SLOTS-1:0] slot_ins,
   input logic [31:0]          ost_event_o,
   input logic [31:0]          ost_status_o,
   input logic                 ost_pulse_o
);
   p_invalid_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !sel_valid) |-> (bus_rdata == 32'd0));

   p_invalid_keeps_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !sel_valid) |=> ($stable(ost_event_o) && $stable(ost_status_o)));

   p_status_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_word == 2'd1) |-> (bus_rdata[31:3] == 29'd0));

   p_add_sets_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (add_req && add_slot < SEL_W'(MAX_SLOTS - 1) + SEL_W'(1)) |=> slot_ins[$past(add_slot)]);

   p_scan_none_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_go && !scan_found) |=> $stable(sel_q));

   p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ost_pulse_o |-> $past(bus_wr && bus_word == 2'd2 && cmd_q == 8'd2 && sel_valid));
endmodule

bind cpuhp_regs cpuhp_regs_chk #(.MAX_SLOTS(MAX_SLOTS), .SEL_W(SEL_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_word     (bus_word),
   .bus_rdata    (bus_rdata),
   .add_req      (add_req),
   .add_slot     (add_slot),
   .sel_q        (sel_q),
   .sel_valid    (sel_valid),
   .cmd_q        (cmd_q),
   .scan_go      (scan_go),
   .scan_found   (scan_found),
   .slot_ins     (slot_ins),
   .ost_event_o  (ost_event_o),
   .ost_status_o (ost_status_o),
   .ost_pulse_o  (ost_pulse_o)
);

// File: tb/cpuhp_regs_tb_top.sv
module cpuhp_regs_tb_top;
   localparam int unsigned N  = 6;
   localparam int unsigned SW = 3;
   localparam logic [63:0] IDB = 64'h0000_01C3_8000_0040;
   localparam logic [63:0] IDS = 64'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_word = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic add_req = 1'b0, rem_req = 1'b0;
   logic [SW-1:0] add_slot = '0, rem_slot = '0;
   logic [31:0] ost_event_o, ost_status_o;
   logic ost_pulse_o;

   int checks = 0, errors = 0;

   // model state
   logic [31:0]  m_sel = 0;
   logic [7:0]   m_cmd = 0;
   logic [N-1:0] m_en = 0, m_ins = 0, m_rem = 0;
   logic [31:0]  m_ev = 0, m_st = 0;
   logic         m_pulse = 0;

   always #4 clk = ~clk;

   cpuhp_regs #(.MAX_SLOTS(N), .ID_BASE(IDB), .ID_STRIDE(IDS)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .add_req(add_req), .add_slot(add_slot),
      .rem_req(rem_req), .rem_slot(rem_slot), .ost_event_o(ost_event_o),
      .ost_status_o(ost_status_o), .ost_pulse_o(ost_pulse_o));

   function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
      logic [31:0] r = o;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
      return r;
   endfunction

   function automatic logic [31:0] mask(logic [3:0] be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[8*b +: 8] = {8{be[b]}};
      return r;
   endfunction

   function automatic logic [63:0] id_of(logic [31:0] s);
      return IDB + 64'(s) * IDS;
   endfunction

   function automatic logic [31:0] exp_rd(int w, logic [3:0] be);
      logic [31:0] v = 0;
      if (m_sel < N) begin
         case (w)
            0: if (m_cmd == 3) v = id_of(m_sel) >> 32;
            1: v = {29'd0, m_rem[m_sel], m_ins[m_sel], m_en[m_sel]};
            2: if (m_cmd == 0) v = m_sel; else if (m_cmd == 3) v = id_of(m_sel) & 64'hFFFF_FFFF;
            default: v = 0;
         endcase
      end
      return v & mask(be);
   endfunction

   task automatic chk(logic [31:0] got, logic [31:0] exp, string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_wr(int w, logic [3:0] be, logic [31:0] d);
      bit valid = (m_sel < N);
      m_pulse = 0;
      if (w == 0) m_sel = merge(m_sel, d, be);
      else if (w == 1 && valid) begin
         if (be[1]) begin
            m_cmd = d[15:8];
            if (d[15:8] == 0) begin
               for (int i = N - 1; i >= 0; i--)
                  if (m_ins[i] || m_rem[i]) m_sel = i;
            end
         end
         if (be[0]) begin
            if (d[1]) m_ins[m_sel_before(valid)] = 0;
         end
      end else if (w == 2 && valid) begin
         if (m_cmd == 1) m_ev = merge(m_ev, d, be);
         if (m_cmd == 2) begin m_st = merge(m_st, d, be); m_pulse = 1; end
      end
   endtask

   // placeholder-free helper: ack always applies to selector before this write
   logic [31:0] pre_sel;
   function automatic int m_sel_before(bit v);
      return v ? int'(pre_sel) : 0;
   endfunction

   task automatic wr(int w, logic [3:0] be, logic [31:0] d, string tag);
      logic [N-1:0] ins0, rem0;
      bit valid0;
      @(negedge clk);
      bus_wr = 1; bus_word = w[1:0]; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
      pre_sel = m_sel; valid0 = (m_sel < N); ins0 = m_ins; rem0 = m_rem;
      model_wr(w, be, d);
      if (w == 1 && valid0 && be[0]) begin
         if (d[2]) begin m_rem[pre_sel] = 0; m_en[pre_sel] = 0; end
      end
      chk({31'd0, ost_pulse_o}, {31'd0, m_pulse}, {tag, " R9 pulse"});
      chk(ost_event_o, m_ev, {tag, " R9 event"});
      chk(ost_status_o, m_st, {tag, " R9 status"});
   endtask

   task automatic rd(int w, logic [3:0] be, string tag);
      @(negedge clk);
      bus_rd = 1; bus_word = w[1:0]; bus_be = be;
      #1;
      chk(bus_rdata, exp_rd(w, be), tag);
      bus_rd = 0;
   endtask

   task automatic hot(bit is_add, int s);
      @(negedge clk);
      if (is_add) begin add_req = 1; add_slot = SW'(s); end
      else begin rem_req = 1; rem_slot = SW'(s); end
      @(negedge clk);
      add_req = 0; rem_req = 0;
      if (is_add) begin m_en[s] = 1; m_ins[s] = 1; end
      else m_rem[s] = 1;
   endtask

   task automatic rd_all(string tag);
      rd(0, 4'hF, {tag, " R8 word0"});
      rd(1, 4'hF, {tag, " R3 status"});
      rd(2, 4'hF, {tag, " R7 data"});
   endtask

   initial begin
      #1600000;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int unsigned seed = 32'd12345;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11 reset state, R1 selector starts at 0
      rd(2, 4'hF, "R1 R11 reset data");
      rd(1, 4'hF, "R11 reset status");
      chk(ost_event_o, 0, "R11 reset event");
      chk({31'd0, ost_pulse_o}, 0, "R11 reset pulse");
      // R1 selector write
      wr(0, 4'hF, 32'd4, "R1 sel");
      rd(2, 4'hF, "R1 sel readback");
      wr(0, 4'h1, 32'hFFFF_FF03, "R1 sel byte");
      rd(2, 4'hF, "R1 sel byte readback");
      // R4 hot add, R6 scan ascending
      hot(1, 5); hot(1, 2);
      wr(1, 4'h2, 32'h0000_0000, "R6 scan");
      rd(2, 4'hF, "R6 scan lowest");
      rd(1, 4'hF, "R4 R3 status add");
      wr(1, 4'h1, 32'h0000_0002, "R5 ack ins");
      wr(1, 4'h2, 32'h0000_0000, "R6 scan2");
      rd(2, 4'hF, "R6 scan next");
      wr(1, 4'h1, 32'h0000_0002, "R5 ack ins5");
      wr(1, 4'h2, 32'h0000_0000, "R6 scan none");
      rd(2, 4'hF, "R6 none keeps sel");
      hot(0, 5);
      rd(1, 4'hF, "R4 remove pending");
      wr(1, 4'h1, 32'h0000_0001, "R5 bit0");
      rd(1, 4'hF, "R5 bit0 no effect");
      wr(1, 4'h1, 32'h0000_0004, "R5 ack rem");
      rd(1, 4'hF, "R5 remove cleared");
      // R7 R8 id halves
      wr(1, 4'h2, 32'h0000_0300, "R7 cmd3");
      rd(2, 4'hF, "R7 id low");
      rd(0, 4'hF, "R8 id high");
      wr(1, 4'h2, 32'h0000_0700, "R7 cmd7");
      rd(2, 4'hF, "R7 other cmd zero");
      rd(0, 4'hF, "R8 other cmd zero");
      // R2 invalid selector
      wr(1, 4'h2, 32'h0000_0100, "R9 cmd1");
      wr(0, 4'hF, 32'd6, "R2 sel6");
      rd_all("R2 invalid");
      wr(2, 4'hF, 32'hDEAD_BEEF, "R2 blocked event");
      wr(1, 4'h2, 32'h0000_0300, "R2 blocked cmd");
      wr(0, 4'h1, 32'd7, "R2 sel7");
      rd(1, 4'hF, "R2 sel7 status");
      wr(0, 4'hF, 32'd1, "R2 restore");
      rd(2, 4'hF, "R2 cmd kept (data 0 for cmd1)");
      wr(2, 4'hF, 32'h1234_5678, "R9 event write");
      wr(1, 4'h2, 32'h0000_0200, "R9 cmd2");
      wr(2, 4'h3, 32'hAAAA_9876, "R9 status write");
      // R10 reserved
      wr(3, 4'hF, 32'hFFFF_FFFF, "R10 word3 write");
      rd(3, 4'hF, "R10 word3 read");
      hot(1, 1);
      rd(1, 4'hE, "R10 status masked");
      rd(1, 4'hC, "R10 upper bytes");
      // R1 reset keeps selector, R11 clears rest
      wr(0, 4'hF, 32'd3, "R1 sel3");
      hot(1, 3);
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      m_cmd = 0; m_en = 0; m_ins = 0; m_rem = 0; m_ev = 0; m_st = 0;
      rd(2, 4'hF, "R1 sel after reset");
      rd(1, 4'hF, "R11 flags after reset");
      chk(ost_status_o, 0, "R11 status after reset");
      // random phase
      for (int it = 0; it < 500; it++) begin
         int op = $urandom_range(0, 9);
         if (op == 0) hot(1, $urandom_range(0, N - 1));
         else if (op == 1) hot(0, $urandom_range(0, N - 1));
         else if (op == 2) wr(0, 4'hF, ($urandom_range(0, 15) == 0) ? $urandom : $urandom_range(0, N + 1), "R1 rnd sel");
         else if (op <= 5) wr(1, 4'(1 << $urandom_range(0, 1)) | 4'($urandom_range(0, 1)),
                              {16'd0, 8'($urandom_range(0, 4)), 5'd0, 3'($urandom)}, "R6 rnd ctl");
         else if (op <= 7) wr(2, 4'($urandom_range(1, 15)), $urandom, "R9 rnd data");
         else wr(0, 4'hF, 32'($urandom_range(0, N - 1)), "R1 rnd valid sel");
         rd_all("R7 rnd");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule